// File: doc/BRIEF.md
# Conditional Execution Pass Evaluator

This unit decides whether a trapped 32-bit instruction would have executed under its condition. It takes the trap syndrome word, the saved program status word and an input strobe. One clock later it returns a single pass bit together with an output strobe. The condition comes from the syndrome when the syndrome marks it valid. Otherwise it is recovered from the if-then state that the status word keeps in two separate slices.

The decision is a lookup into sixteen 16-bit masks. The condition code selects the mask, and the four flag bits pick one bit of it. Syndrome words whose two top bits are not both zero stand for unconditional encodings and always pass. The result and its strobe come from registers, so the unit can sit on an FPGA pipeline stage with no extra timing path.

Top module: `cond_pass_eval`

## Requirements
- R1: When syndrome[31:30] is nonzero, the registered result is pass (1), whatever the other inputs are.
- R2: When the syndrome condition-valid bit (syndrome[24]) is 1 and the condition field syndrome[23:20] equals 4'hE, the result is pass for every flag value.
- R3: The flag nibble is status[31:28], read as {N,Z,C,V}. The result is bit {N,Z,C,V} of the 16-bit mask chosen by the effective condition.
- R4: Conditions 0 to 7 behave as EQ (Z), NE (!Z), CS (C), CC (!C), MI (N), PL (!N), VS (V) and VC (!V).
- R5: Conditions 8 to 15 behave as HI (C && !Z), LS (!C || Z), GE (N==V), LT (N!=V), GT (!Z && N==V), LE (Z || N!=V), always and never. Condition 15 never passes.
- R6: When syndrome[24] is 0, the syndrome condition field is ignored. An if-then byte is formed with bits [7:2] = status[15:10] and bits [1:0] = status[26:25], and the effective condition is its bits [7:4].
- R7: When syndrome[24] is 0 and the if-then byte is zero, the result is pass.
- R8: out_valid is high in exactly the cycle after a cycle in which in_valid was high, and the result for that input appears on out_pass in the same cycle.
- R9: A synchronous active-high reset clears out_valid and out_pass at the next clock edge.
- R10: While in_valid is low, out_pass keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe for syndrome and status |
| syndrome | input | 32 | Trap syndrome word |
| status | input | 32 | Saved program status word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_pass | output | 1 | 1 when the instruction should have executed |

## Verification
All 256 pairs of condition code and flag nibble are run with the syndrome condition marked valid, and each result is compared with flag equations written separately from any mask constant. This separates a wrong mask bit from a wrong flag ordering. Directed vectors then place a condition in the syndrome that disagrees with the if-then condition in the status word. These show which source the unit obeys, that both status slices feed the if-then byte, and that the top syndrome bits override everything else. Reset, idle-cycle hold and strobe timing are checked apart from these.

// File: rtl/cond_pass_pkg.sv
package cond_pass_pkg;
  localparam int WORD_W = 32;
  localparam int CC_W   = 4;
  localparam int MASK_W = 1 << CC_W;
  localparam int IT_W   = 8;
  localparam logic [CC_W-1:0] CC_ALWAYS = 4'hE;

  typedef logic [CC_W-1:0]   cc_t;
  typedef logic [MASK_W-1:0] cc_mask_t;

  typedef struct packed {
    logic force_pass;
    cc_t  code;
  } cond_sel_t;
endpackage

// File: rtl/cc_mask_lut.sv
module cc_mask_lut
  import cond_pass_pkg::*;
(
  input  cc_t      code,
  output cc_mask_t mask
);
  // Each mask bit is indexed by {N,Z,C,V}.
  always_comb begin
    unique case (code)
      4'h0: mask = 16'hF0F0;
      4'h1: mask = 16'h0F0F;
      4'h2: mask = 16'hCCCC;
      4'h3: mask = 16'h3333;
      4'h4: mask = 16'hFF00;
      4'h5: mask = 16'h00FF;
      4'h6: mask = 16'hAAAA;
      4'h7: mask = 16'h5555;
      4'h8: mask = 16'h0C0C;
      4'h9: mask = 16'hF3F3;
      4'hA: mask = 16'hAA55;
      4'hB: mask = 16'h55AA;
      4'hC: mask = 16'h0A05;
      4'hD: mask = 16'hF5FA;
      4'hE: mask = 16'hFFFF;
      default: mask = 16'h0000;
    endcase
  end
endmodule

// File: rtl/it_state_extract.sv
module it_state_extract
  import cond_pass_pkg::*;
#(
  parameter int HI_LSB = 10,
  parameter int LO_LSB = 25
)(
  input  logic [WORD_W-1:0] status,
  output logic [IT_W-1:0]   it_byte,
  output logic              it_zero,
  output cc_t               it_code
);
  localparam int HI_W = IT_W - 2;

  assign it_byte = {status[HI_LSB +: HI_W], status[LO_LSB +: 2]};
  assign it_zero = (it_byte == '0);
  assign it_code = it_byte[IT_W-1 -: CC_W];
endmodule

// File: rtl/cond_source_sel.sv
module cond_source_sel
  import cond_pass_pkg::*;
#(
  parameter int CV_BIT   = 24,
  parameter int CODE_LSB = 20
)(
  input  logic [WORD_W-1:0] syndrome,
  input  logic              it_zero,
  input  cc_t               it_code,
  output cond_sel_t         sel
);
  logic uncond_enc;
  logic cv;
  cc_t  syn_code;

  assign uncond_enc = |syndrome[WORD_W-1 -: 2];
  assign cv         = syndrome[CV_BIT];
  assign syn_code   = syndrome[CODE_LSB +: CC_W];

  always_comb begin
    sel.force_pass = 1'b0;
    sel.code       = syn_code;
    if (uncond_enc) begin
      sel.force_pass = 1'b1;
    end else if (cv) begin
      sel.force_pass = (syn_code == CC_ALWAYS);
    end else begin
      sel.code       = it_code;
      sel.force_pass = it_zero;
    end
  end
endmodule

// File: rtl/cond_pass_eval.sv
module cond_pass_eval
  import cond_pass_pkg::*;
#(
  parameter int CV_BIT    = 24,
  parameter int CODE_LSB  = 20,
  parameter int FLAG_LSB  = 28,
  parameter int IT_HI_LSB = 10,
  parameter int IT_LO_LSB = 25
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] syndrome,
  input  logic [31:0] status,
  output logic        out_valid,
  output logic        out_pass
);
  logic [IT_W-1:0] it_byte;
  logic            it_zero;
  cc_t             it_code;
  cond_sel_t       sel;
  cc_mask_t        mask;
  cc_t             nzcv;
  logic            pass_d;

  it_state_extract #(.HI_LSB(IT_HI_LSB), .LO_LSB(IT_LO_LSB)) u_it (
    .status (status),
    .it_byte(it_byte),
    .it_zero(it_zero),
    .it_code(it_code)
  );

  cond_source_sel #(.CV_BIT(CV_BIT), .CODE_LSB(CODE_LSB)) u_sel (
    .syndrome(syndrome),
    .it_zero (it_zero),
    .it_code (it_code),
    .sel     (sel)
  );

  cc_mask_lut u_lut (
    .code(sel.code),
    .mask(mask)
  );

  assign nzcv   = status[FLAG_LSB +: CC_W];
  assign pass_d = sel.force_pass | mask[nzcv];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pass  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pass <= pass_d;
    end
  end

  p_uncond_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && |syndrome[31:30]) |=> out_pass);

  p_always_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && syndrome[31:30] == 2'b00 && syndrome[CV_BIT] &&
     syndrome[CODE_LSB +: CC_W] == 4'hE) |=> out_pass);

  p_never_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && syndrome[31:30] == 2'b00 && syndrome[CV_BIT] &&
     syndrome[CODE_LSB +: CC_W] == 4'hF) |=> !out_pass);

  p_it_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && syndrome[31:30] == 2'b00 && !syndrome[CV_BIT] &&
     status[IT_HI_LSB +: 6] == 6'd0 && status[IT_LO_LSB +: 2] == 2'd0) |=> out_pass);

  p_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_pass));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_pass));
endmodule

// File: tb/tb_cond_pass_eval.sv
module tb_cond_pass_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] syndrome;
  logic [31:0] status;
  logic        out_valid;
  logic        out_pass;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_pass_eval dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .syndrome(syndrome), .status(status),
    .out_valid(out_valid), .out_pass(out_pass)
  );

  // {syndrome, status, expected pass}
  localparam logic [64:0] VEC [NVEC] = '{
    {32'hC000_0000, 32'h0000_F000, 1'b1},  // R1 top bits override NV from IT
    {32'h41F0_0000, 32'h0000_0000, 1'b1},  // R1 overrides NV field
    {32'h01E0_0000, 32'h0000_0000, 1'b1},  // R2 always
    {32'h01F0_0000, 32'hF000_0000, 1'b0},  // R5 never
    {32'h0000_0000, 32'h0000_0000, 1'b1},  // R7 IT zero
    {32'h0000_0000, 32'h0000_0400, 1'b0},  // R6 IT=01, EQ with Z=0
    {32'h0000_0000, 32'h0200_0000, 1'b0},  // R6 low slice only, EQ, Z=0
    {32'h0000_0000, 32'h4200_0000, 1'b1},  // R6 low slice, EQ, Z=1
    {32'h0000_0000, 32'h8000_C000, 1'b0},  // R6 GT from IT, N!=V
    {32'h0000_0000, 32'h9000_C000, 1'b1},  // R6 GT from IT, N==V
    {32'h0100_0000, 32'h0000_E000, 1'b0},  // R6 CV=1 ignores IT: EQ, Z=0
    {32'h00E0_0000, 32'h0000_F000, 1'b0}   // R6 CV=0 ignores field: NV from IT
  };

  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy && !z;
      4'h9: return !cy || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] syn, input logic [31:0] st);
    @(negedge clk);
    syndrome = syn;
    status   = st;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; syndrome = '0; status = '0;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", out_valid, 1'b0);
    check("R9 reset out_pass", out_pass, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][64:33], VEC[i][32:1]);
      check("R8 strobe", out_valid, 1'b1);
      check($sformatf("R1/R2/R5/R6/R7 vector %0d", i), out_pass, VEC[i][0]);
    end

    // R3 R4 R5: every condition against every flag nibble
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply({8'h01, 4'(c), 20'h0}, {4'(f), 28'h0});
        check($sformatf("R3/R4/R5 cc=%0h nzcv=%0h", c, f), out_pass,
              ref_pass(4'(c), 4'(f)));
      end
    end

    // R10: a pass result held while an idle failing input is present
    apply(32'h01E0_0000, 32'h0);
    check("R10 setup", out_pass, 1'b1);
    syndrome = 32'h01F0_0000;
    @(negedge clk);
    @(negedge clk);
    check("R8 idle out_valid", out_valid, 1'b0);
    check("R10 hold", out_pass, 1'b1);

    // R9: reset wins over a strobe
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R9 mid-run out_valid", out_valid, 1'b0);
    check("R9 mid-run out_pass", out_pass, 1'b0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R8 after reset", out_valid, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule